// File: doc/BRIEF.md
# Batched register command sequencer

This block sits between a host command stream and a local register bus. The host sends a sequence of simple commands: a register write, a register read, or a register test. A test reads a register and compares the masked value with an expected one, retrying on every cycle until it matches. The host can then send a whole handshake procedure in one go. The block performs every bus access and every poll locally, so the host does not pay a link round trip for each handshake step.

A batch is a run of commands that an end-of-batch command closes. The mode flag on the first command of a batch selects how the batch reports. In batch mode, per-command replies are suppressed. Only one reply comes back at the end: either plain success, or the zero-based position of the first failing command together with the kind of failure. Once a failure has occurred, the remaining commands up to the end marker are swallowed without touching the bus. In immediate mode, each command produces its own reply as soon as it finishes, so the host can inspect it before it continues.

Top module: `regseq_top`

## Requirements
- R1: A write command (cmd_op 00) drives exactly one bus cycle with bus_we high, carrying the command's address and data.
- R2: A read command (cmd_op 01) drives one bus read. In immediate mode it answers with rsp_code 0 and the read word in rsp_data.
- R3: A test command (cmd_op 10) reads the addressed register on consecutive cycles. It passes as soon as `(rdata & mask) == (data & mask)`. After RETRY_LIMIT reads without a match it fails with a mismatch.
- R4: In immediate mode, writes, tests and bus-errored reads answer with rsp_code 1. The status word is rsp_data[0] = failed and rsp_data[1] = bus error, with all other bits zero.
- R5: In batch mode, no command except end-of-batch (cmd_op 11) produces a reply. A batch closed with no failure answers once with rsp_code 2 and rsp_data zero.
- R6: In batch mode, the first failure is reported at end-of-batch with rsp_code 3. rsp_data[15:0] holds that command's index, counted from zero. rsp_data[16] holds the failure type (0 = mismatch after retries, 1 = bus error). Later commands in the batch cause no bus access.
- R7: cmd_batch is taken from the first command of a batch only, and end-of-batch closes the batch. An end-of-batch command arriving outside an open batch forms an empty batch.
- R8: cmd_ready is low while a bus access or test retry is in progress, and while a reply is waiting on the response port.
- R9: A pending reply keeps rsp_valid, rsp_code and rsp_data unchanged until rsp_ready is high.
- R10: After reset, cmd_ready is high and both rsp_valid and bus_req are low.
- R11: End-of-batch in immediate mode produces no reply.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted when high together with cmd_valid |
| cmd_op | input | 2 | 00 write, 01 read, 10 test, 11 end-of-batch |
| cmd_batch | input | 1 | Mode flag, 1 = batch, used on the first command of a batch |
| cmd_addr | input | ADDR_W | Register address |
| cmd_data | input | DATA_W | Write data or expected test value |
| cmd_mask | input | DATA_W | Compare mask for tests |
| bus_req | output | 1 | Bus access this cycle |
| bus_we | output | 1 | Access is a write |
| bus_addr | output | ADDR_W | Bus address |
| bus_wdata | output | DATA_W | Bus write data |
| bus_rdata | input | DATA_W | Read data, valid in the request cycle |
| bus_err | input | 1 | Error response, valid in the request cycle |
| rsp_valid | output | 1 | Reply present |
| rsp_ready | input | 1 | Reply consumed when high together with rsp_valid |
| rsp_code | output | 2 | 0 data, 1 status, 2 batch success, 3 batch failure |
| rsp_data | output | DATA_W | Reply payload |

## Verification
The sequencer is driven with single commands in immediate mode and with several batches: a batch with no failure, a batch that fails on a mismatch partway through, a batch that fails on a bus error, and an empty batch. Comparing these shows whether replies are suppressed, and whether the failure index and type point at the right command. Tests are run against a polled counter register that matches only after several reads, and against a fixed register that never matches. This separates the pass-on-retry case from the retry budget running out, and a later read of the counter shows exactly how many polls were made. Writes sent after a batch failure are read back afterwards to show that dropped commands never reached the bus. Random response back-pressure checks that replies are held and that new commands are stalled.

// File: rtl/regseq_pkg.sv
// Shared encodings for the batched register command sequencer.
// Assumes the command opcode and reply code values below are fixed by the host protocol.
package regseq_pkg;
    localparam int ADDR_WIDTH  = 16;
    localparam int DATA_WIDTH  = 32;
    localparam int INDEX_WIDTH = 16;
    localparam int RETRY_WIDTH = 16;

    typedef enum logic [1:0] {
        OP_WRITE = 2'b00,
        OP_READ  = 2'b01,
        OP_TEST  = 2'b10,
        OP_END   = 2'b11
    } seq_op_e;

    typedef enum logic [1:0] {
        RSP_DATA       = 2'd0,
        RSP_STATUS     = 2'd1,
        RSP_BATCH_OK   = 2'd2,
        RSP_BATCH_FAIL = 2'd3
    } rsp_code_e;
endpackage

// File: rtl/regseq_exec.sv
// Executes one write, read or test command on the single-cycle register bus.
// Assumes the bus answers (rdata, err) combinationally in the cycle bus_req is high.
// A test re-reads every cycle until the masked compare matches or the retry budget is spent.
module regseq_exec
    import regseq_pkg::*;
#(
    parameter int ADDR_W      = ADDR_WIDTH,
    parameter int DATA_W      = DATA_WIDTH,
    parameter int RETRY_LIMIT = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  seq_op_e           op_in,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    input  logic [DATA_W-1:0] mask_in,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic              buserr,
    output logic [DATA_W-1:0] rdata,
    output seq_op_e           cur_op,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_err
);
    localparam logic [RETRY_WIDTH-1:0] LAST_TRY = RETRY_WIDTH'(RETRY_LIMIT - 1);

    logic                   act_q;
    seq_op_e                op_q;
    logic [ADDR_W-1:0]      addr_q;
    logic [DATA_W-1:0]      data_q;
    logic [DATA_W-1:0]      mask_q;
    logic [RETRY_WIDTH-1:0] tries_q;
    logic                   match;
    logic                   is_test;

    // Masked compare of the returned word against the expected value.
    assign match   = ((bus_rdata ^ data_q) & mask_q) == '0;
    assign is_test = (op_q == OP_TEST);

    // Completion and outcome of the access in the current cycle.
    assign done   = act_q && (bus_err || !is_test || match || tries_q == LAST_TRY);
    assign fail   = bus_err || (is_test && !match);
    assign buserr = act_q && bus_err;
    assign rdata  = bus_rdata;
    assign cur_op = op_q;
    assign busy   = act_q;

    // Bus master outputs follow the latched command.
    assign bus_req   = act_q;
    assign bus_we    = act_q && (op_q == OP_WRITE);
    assign bus_addr  = addr_q;
    assign bus_wdata = data_q;

    // Latch a command on start, then count attempts until completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q   <= 1'b0;
            op_q    <= OP_WRITE;
            addr_q  <= '0;
            data_q  <= '0;
            mask_q  <= '0;
            tries_q <= '0;
        end else if (start) begin
            act_q   <= 1'b1;
            op_q    <= op_in;
            addr_q  <= addr_in;
            data_q  <= data_in;
            mask_q  <= mask_in;
            tries_q <= '0;
        end else if (act_q) begin
            if (done) act_q <= 1'b0;
            else      tries_q <= tries_q + 1'b1;
        end
    end

    a_r3_retry_bound: assert property (@(posedge clk) disable iff (!rst_n)
        act_q |-> (tries_q <= LAST_TRY));
    a_r1_write_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we) |=> !bus_req);
    a_r6_err_ends_access: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_err && !start) |=> !bus_req);
endmodule

// File: rtl/regseq_resp.sv
// Single-entry reply register for the valid/ready response stream.
// Assumes the loader only loads when no reply is pending.
module regseq_resp #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [1:0]        code_in,
    input  logic [DATA_W-1:0] data_in,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [1:0]        rsp_code,
    output logic [DATA_W-1:0] rsp_data
);
    // Hold a reply from load until the consumer takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_code  <= '0;
            rsp_data  <= '0;
        end else if (load) begin
            rsp_valid <= 1'b1;
            rsp_code  <= code_in;
            rsp_data  <= data_in;
        end else if (rsp_ready) begin
            rsp_valid <= 1'b0;
        end
    end

    a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_code) && $stable(rsp_data)));
    a_r8_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !rsp_valid);
endmodule

// File: rtl/regseq_top.sv
// Batched register command sequencer: accepts host commands, runs them on the register bus,
// and reports per command (immediate mode) or once per batch (batch mode).
// Assumes DATA_W > INDEX_W so the failure index and type fit in one reply word.
module regseq_top
    import regseq_pkg::*;
#(
    parameter int ADDR_W      = ADDR_WIDTH,
    parameter int DATA_W      = DATA_WIDTH,
    parameter int INDEX_W     = INDEX_WIDTH,
    parameter int RETRY_LIMIT = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [1:0]        cmd_op,
    input  logic              cmd_batch,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic [DATA_W-1:0] cmd_mask,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_err,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [1:0]        rsp_code,
    output logic [DATA_W-1:0] rsp_data
);
    seq_op_e              op_in;
    logic                 accept, start, is_end;
    logic                 in_batch_q, mode_q, failed_q, ftype_q;
    logic [INDEX_W-1:0]   idx_q, fidx_q, exec_idx_q;
    logic                 eff_mode, eff_failed;
    logic [INDEX_W-1:0]   eff_idx;
    logic                 ex_busy, ex_done, ex_fail, ex_buserr;
    logic [DATA_W-1:0]    ex_rdata;
    seq_op_e              ex_op;
    logic                 rsp_load;
    logic [1:0]           rsp_code_n;
    logic [DATA_W-1:0]    rsp_data_n;

    // Command acceptance and effective batch context for the incoming command.
    assign op_in      = seq_op_e'(cmd_op);
    assign is_end     = (op_in == OP_END);
    assign cmd_ready  = !ex_busy && !rsp_valid;
    assign accept     = cmd_valid && cmd_ready;
    assign eff_mode   = in_batch_q ? mode_q   : cmd_batch;
    assign eff_failed = in_batch_q ? failed_q : 1'b0;
    assign eff_idx    = in_batch_q ? idx_q    : '0;
    assign start      = accept && !is_end && !eff_failed;

    regseq_exec #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .RETRY_LIMIT (RETRY_LIMIT)
    ) i_exec (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .op_in     (op_in),
        .addr_in   (cmd_addr),
        .data_in   (cmd_data),
        .mask_in   (cmd_mask),
        .busy      (ex_busy),
        .done      (ex_done),
        .fail      (ex_fail),
        .buserr    (ex_buserr),
        .rdata     (ex_rdata),
        .cur_op    (ex_op),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_err   (bus_err)
    );

    // Batch framing, command index and first-failure capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_batch_q <= 1'b0;
            mode_q     <= 1'b0;
            failed_q   <= 1'b0;
            ftype_q    <= 1'b0;
            idx_q      <= '0;
            fidx_q     <= '0;
            exec_idx_q <= '0;
        end else begin
            if (accept) begin
                if (is_end) begin
                    in_batch_q <= 1'b0;
                    failed_q   <= 1'b0;
                    idx_q      <= '0;
                end else begin
                    in_batch_q <= 1'b1;
                    mode_q     <= eff_mode;
                    failed_q   <= eff_failed;
                    idx_q      <= eff_idx + 1'b1;
                    exec_idx_q <= eff_idx;
                end
            end
            if (ex_done && mode_q && ex_fail) begin
                failed_q <= 1'b1;
                fidx_q   <= exec_idx_q;
                ftype_q  <= ex_buserr;
            end
        end
    end

    // Reply selection: batch verdict at end marker, or per-command reply in immediate mode.
    always_comb begin
        rsp_load   = 1'b0;
        rsp_code_n = RSP_DATA;
        rsp_data_n = '0;
        if (accept && is_end && eff_mode) begin
            rsp_load = 1'b1;
            if (eff_failed) begin
                rsp_code_n             = RSP_BATCH_FAIL;
                rsp_data_n[INDEX_W-1:0] = fidx_q;
                rsp_data_n[INDEX_W]     = ftype_q;
            end else begin
                rsp_code_n = RSP_BATCH_OK;
            end
        end else if (ex_done && !mode_q) begin
            rsp_load = 1'b1;
            if (ex_op == OP_READ && !ex_fail) begin
                rsp_code_n = RSP_DATA;
                rsp_data_n = ex_rdata;
            end else begin
                rsp_code_n    = RSP_STATUS;
                rsp_data_n[0] = ex_fail;
                rsp_data_n[1] = ex_buserr;
            end
        end
    end

    regseq_resp #(
        .DATA_W (DATA_W)
    ) i_resp (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (rsp_load),
        .code_in   (rsp_code_n),
        .data_in   (rsp_data_n),
        .rsp_valid (rsp_valid),
        .rsp_ready (rsp_ready),
        .rsp_code  (rsp_code),
        .rsp_data  (rsp_data)
    );

    a_r8_stall_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (bus_req && !cmd_ready));
    a_r5_end_gives_verdict: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && is_end && eff_mode) |=> (rsp_valid && rsp_code[1]));
    a_r5_batch_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_done && mode_q) |=> !rsp_valid);
    a_r6_dropped_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && eff_failed) |=> !bus_req);
    a_r11_imm_end_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && is_end && !eff_mode) |=> !rsp_valid);
endmodule

// File: tb/test_regseq_top.sv
// Bench for the batched register command sequencer: a behavioural bus slave, a behavioural
// reference model that predicts every reply, and per-clock checks on the handshakes.
module test_regseq_top;
    localparam int LIM = 100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [1:0]  cmd_op = 2'd0;
    logic        cmd_batch = 1'b0;
    logic [15:0] cmd_addr = '0;
    logic [31:0] cmd_data = '0;
    logic [31:0] cmd_mask = '0;
    logic        bus_req, bus_we;
    logic [15:0] bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic        bus_err;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic [1:0]  rsp_code;
    logic [31:0] rsp_data;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit bp_en = 1'b0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    regseq_top #(.RETRY_LIMIT(LIM)) i_regseq_top (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_batch(cmd_batch),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_mask(cmd_mask),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_err(bus_err),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_code(rsp_code), .rsp_data(rsp_data)
    );

    // Bus slave: 16 plain registers, a counter at 0x20 that advances per read, errors from 0x100 up.
    logic [31:0] sregs [16];
    logic [31:0] scnt;
    assign bus_err   = bus_req && (bus_addr >= 16'h0100);
    assign bus_rdata = (bus_addr < 16'd16) ? sregs[bus_addr[3:0]] :
                       (bus_addr == 16'h0020) ? scnt : 32'd0;
    always @(posedge clk) begin
        if (!rst_n) begin
            scnt <= 0;
            for (int i = 0; i < 16; i++) sregs[i] <= 0;
        end else if (bus_req && !bus_err) begin
            if (bus_we && bus_addr < 16'd16) sregs[bus_addr[3:0]] <= bus_wdata;
            if (!bus_we && bus_addr == 16'h0020) scnt <= scnt + 1;
        end
    end

    // Response back-pressure pattern.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        rsp_ready <= !bp_en || (cyc % 3 == 2);
    end

    // Reference model state.
    logic [31:0] mregs [16];
    logic [31:0] mcnt = 0;
    bit bm_in = 0, bm_mode = 0, bm_fail = 0, bm_ftype = 0;
    int bm_idx = 0, bm_fidx = 0;
    logic [1:0]  q_code [$];
    logic [31:0] q_data [$];
    string       q_tag  [$];

    initial for (int i = 0; i < 16; i++) mregs[i] = 0;

    function automatic logic [31:0] mread(input logic [15:0] a);
        logic [31:0] v;
        v = 0;
        if (a < 16) v = mregs[a[3:0]];
        else if (a == 16'h0020) begin v = mcnt; mcnt = mcnt + 1; end
        return v;
    endfunction

    task automatic push(input logic [1:0] c, input logic [31:0] d, input string t);
        q_code.push_back(c); q_data.push_back(d); q_tag.push_back(t);
    endtask

    task automatic model_cmd(input logic [1:0] op, input logic b, input logic [15:0] a,
                             input logic [31:0] d, input logic [31:0] m, input string tag);
        int idx; bit berr, fl; logic [31:0] v;
        if (!bm_in) begin bm_in = 1; bm_mode = b; bm_fail = 0; bm_idx = 0; end
        if (op == 2'd3) begin
            if (bm_mode) begin
                if (bm_fail) push(2'd3, {15'd0, bm_ftype, 16'(bm_fidx)}, tag);
                else         push(2'd2, 32'd0, tag);
            end
            bm_in = 0;
            return;
        end
        idx = bm_idx; bm_idx++;
        if (bm_fail) return;
        berr = (a >= 16'h0100); fl = berr; v = 0;
        if (!berr) begin
            if (op == 2'd0 && a < 16) mregs[a[3:0]] = d;
            if (op == 2'd1) v = mread(a);
            if (op == 2'd2) begin
                fl = 1;
                for (int k = 0; k < LIM; k++) begin
                    v = mread(a);
                    if (((v ^ d) & m) == 0) begin fl = 0; break; end
                end
            end
        end
        if (bm_mode) begin
            if (fl) begin bm_fail = 1; bm_fidx = idx; bm_ftype = berr; end
        end else if (op == 2'd1 && !berr) push(2'd0, v, tag);
        else push(2'd1, {30'd0, berr, fl}, tag);
    endtask

    task automatic send(input logic [1:0] op, input logic b, input logic [15:0] a,
                        input logic [31:0] d, input logic [31:0] m, input string tag);
        @(negedge clk);
        cmd_valid = 1; cmd_op = op; cmd_batch = b; cmd_addr = a; cmd_data = d; cmd_mask = m;
        while (!cmd_ready) @(negedge clk);
        model_cmd(op, b, a, d, m, tag);
        @(posedge clk);
        #1 cmd_valid = 0;
    endtask

    // Per-clock comparison of the response port and the stall rules against the model.
    bit pv = 0, pr = 0; logic [1:0] pc; logic [31:0] pd;
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (pv && !pr) begin
                checks++;
                if (!(rsp_valid && rsp_code == pc && rsp_data == pd)) begin
                    errors++;
                    $display("FAIL R9 held reply changed: got v=%0b c=%0d d=%h exp c=%0d d=%h",
                             rsp_valid, rsp_code, rsp_data, pc, pd);
                end
            end
            if (rsp_valid) begin
                checks++;
                if (cmd_ready) begin
                    errors++;
                    $display("FAIL R8 cmd_ready high with pending reply: got 1 exp 0");
                end
            end
            if (rsp_valid && rsp_ready) begin
                checks++;
                if (q_code.size() == 0) begin
                    errors++;
                    $display("FAIL R5 unexpected reply: got c=%0d d=%h exp none", rsp_code, rsp_data);
                end else begin
                    logic [1:0] ec; logic [31:0] ed; string et;
                    ec = q_code.pop_front(); ed = q_data.pop_front(); et = q_tag.pop_front();
                    if (rsp_code != ec || rsp_data != ed) begin
                        errors++;
                        $display("FAIL %s reply mismatch: got c=%0d d=%h exp c=%0d d=%h",
                                 et, rsp_code, rsp_data, ec, ed);
                    end
                end
            end
            pv = rsp_valid; pr = rsp_ready; pc = rsp_code; pd = rsp_data;
        end
    end

    task automatic report();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        if (cyc > 100000 && !finished) begin
            checks++; errors++;
            $display("FAIL watchdog expired: got hang exp completion");
            report();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (!(cmd_ready && !rsp_valid && !bus_req)) begin
            errors++;
            $display("FAIL R10 reset state: got rdy=%0b v=%0b req=%0b exp 1 0 0",
                     cmd_ready, rsp_valid, bus_req);
        end
        rst_n = 1;

        // Immediate mode
        send(2'd0, 0, 16'd3, 32'hA5A5_1234, 32'h0, "R1");
        send(2'd1, 0, 16'd3, 32'h0, 32'h0, "R2");
        send(2'd2, 0, 16'd3, 32'h0000_0034, 32'h0000_00FF, "R3");
        send(2'd2, 0, 16'd3, 32'h0000_0035, 32'h0000_00FF, "R3");
        send(2'd1, 0, 16'h0300, 32'h0, 32'h0, "R4");
        send(2'd0, 0, 16'h0300, 32'h1, 32'h0, "R4");
        send(2'd2, 0, 16'h0020, 32'd5, 32'h0000_00FF, "R3");
        send(2'd1, 0, 16'h0020, 32'h0, 32'h0, "R3");
        send(2'd3, 0, 16'h0, 32'h0, 32'h0, "R11");

        bp_en = 1;
        // Batch with no failure; later flags are ignored (R7)
        send(2'd0, 1, 16'd5, 32'h0000_1111, 32'h0, "R5");
        send(2'd2, 0, 16'h0020, 32'd10, 32'h0000_00FF, "R5");
        send(2'd1, 0, 16'd5, 32'h0, 32'h0, "R5");
        send(2'd3, 0, 16'h0, 32'h0, 32'h0, "R5");

        // Batch failing on a mismatch at index 2; then dropped commands
        send(2'd0, 1, 16'd6, 32'h0000_2222, 32'h0, "R6");
        send(2'd0, 0, 16'd7, 32'h0000_3333, 32'h0, "R6");
        send(2'd2, 0, 16'd6, 32'h0000_9999, 32'h0000_FFFF, "R6");
        send(2'd0, 0, 16'd5, 32'hDEAD_BEEF, 32'h0, "R6");
        send(2'd2, 0, 16'h0300, 32'h0, 32'h0, "R6");
        send(2'd3, 1, 16'h0, 32'h0, 32'h0, "R6");
        send(2'd1, 0, 16'd5, 32'h0, 32'h0, "R6");

        // Batch failing on a bus error at index 1
        send(2'd1, 1, 16'd2, 32'h0, 32'h0, "R6");
        send(2'd0, 0, 16'h0400, 32'h5, 32'h0, "R6");
        send(2'd3, 0, 16'h0, 32'h0, 32'h0, "R6");

        // Empty batch
        send(2'd3, 1, 16'h0, 32'h0, 32'h0, "R7");

        // Retry budget on the counter, then read the counter back
        send(2'd2, 0, 16'h0020, 32'hFFFF_FFFF, 32'hFFFF_0000, "R3");
        send(2'd1, 0, 16'h0020, 32'h0, 32'h0, "R3");
        send(2'd1, 0, 16'd7, 32'h0, 32'h0, "R1");

        bp_en = 0;
        for (int w = 0; w < 200 && (q_code.size() != 0 || rsp_valid); w++) @(negedge clk);
        repeat (5) @(negedge clk);
        checks++;
        if (q_code.size() != 0) begin
            errors++;
            $display("FAIL R5 missing replies: got %0d outstanding exp 0", q_code.size());
        end
        report();
    end
endmodule